// File: doc/BRIEF.md
# DDR2 Extended Mode Register Programmer

This controller-side block writes the first extended mode register of a DDR2 memory device. A client offers a set of configuration fields through a valid/ready handshake. The block captures them, packs them onto the device address bus, waits until every bank is precharged and the clock enable is high, and then drives the register-load command for exactly one clock. It then holds off any further command for the mode-register cycle time.

Alongside the command path, the block keeps a read lockout. Any DLL reset, signalled by a pulse from the controller, and any self-refresh period, during which the DLL is off and after which it is reset, blocks reads for a parameterised number of cycles. Reads also stay blocked until the register has been written at least once after power-up, because its contents are undefined until then. They stay blocked while the last value written keeps the DLL disabled.

The command path is a four-state machine:
- `ST_IDLE` waits for a request and takes it on `req_valid` (transition *accept*).
- `ST_WAIT_GATE` holds the request until `banks_idle && cke_high` (transition *gate open*).
- `ST_ISSUE` drives the command for one cycle. It goes to `ST_MRD_WAIT` (transition *fire*), or straight back to idle when `TMRD` is 1.
- `ST_MRD_WAIT` counts out the rest of `TMRD` and returns to `ST_IDLE` (transition *cycle time met*).

Top module: `ddr2_ext_mode_prog`

## Requirements
- R1: After reset, the strobes show NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1), `ba`=0, `addr`=0, `busy`=0, `req_ready`=1 and `read_allowed`=0.
- R2: An accepted request produces exactly one command cycle with `cs_n`, `ras_n`, `cas_n` and `we_n` all 0 and `ba`=2'b01 (bit 1 low, bit 0 high). In every other cycle the strobes show NOP, with `ba`=0 and `addr`=0.
- R3: During the command cycle the address bits are set as follows. A0 = `cfg_dll_off` (1 means DLL disabled) and A1 = `cfg_half_drive`. A2 = `cfg_odt[0]` and A6 = `cfg_odt[1]`. A5..A3 = `cfg_add_lat`, A9..A7 = `cfg_ocd`, A10 = `cfg_dqs_off`, A11 = `cfg_rdqs_on` and A12 = `cfg_out_off` (1 turns the data outputs off). All higher bits are 0.
- R4: The command is issued only in the cycle after one in which `banks_idle` and `cke_high` were both high. Until then the request stays pending with `busy`=1.
- R5: After a command, `busy` stays high and `req_ready` low for `TMRD`-1 further cycles, so two commands are at least `TMRD` cycles apart (default 2).
- R6: `req_ready` is high exactly when the block is idle. The fields are captured in the accepting cycle, and later changes to the field inputs do not alter the issued address.
- R7: A `dll_reset_evt` pulse keeps `read_allowed` low for `DLL_LOCK_CYC` cycles (default 200) after the cycle in which it was sampled.
- R8: `read_allowed` is low while `self_refresh` is high. It stays low for `DLL_LOCK_CYC` cycles after the last cycle sampled high.
- R9: `read_allowed` stays 0 until a first command has been issued after reset. It is 0 whenever the last command issued had A0=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New field set offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| cfg_dll_off | input | 1 | 1 disables the DLL |
| cfg_half_drive | input | 1 | 1 selects half-strength output driver |
| cfg_odt | input | 2 | Termination setting (bit 1 to A6, bit 0 to A2) |
| cfg_add_lat | input | 3 | Additive latency code |
| cfg_ocd | input | 3 | Off-chip driver calibration control |
| cfg_dqs_off | input | 1 | 1 disables the differential strobe |
| cfg_rdqs_on | input | 1 | 1 enables the read strobe |
| cfg_out_off | input | 1 | 1 turns the data outputs off |
| banks_idle | input | 1 | All banks precharged |
| cke_high | input | 1 | Clock enable is high |
| dll_reset_evt | input | 1 | Single-cycle pulse: DLL was reset |
| self_refresh | input | 1 | Device in self-refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Device address bus |
| busy | output | 1 | Request pending, issuing or counting cycle time |
| read_allowed | output | 1 | Reads may be issued |

## Verification
A request accepted at clock edge *a* leaves the command on the pins during the cycle after edge *a*+1, when the gate is open. `busy` stays high until edge *a*+1+`TMRD`. The bench drives and samples on falling edges and steps exactly that many falling edges before each look. For the lockout, a pulse sampled at edge *e* keeps `read_allowed` low through edge *e*+`DLL_LOCK_CYC`-1 and raises it after edge *e*+`DLL_LOCK_CYC`. The bench checks the last low cycle and the first high cycle on either side of that boundary, both for the pulse and for the end of self-refresh.

// File: rtl/ddr2_emr_pkg.sv
package ddr2_emr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_GATE,
        ST_ISSUE,
        ST_MRD_WAIT
    } emr_state_e;

    typedef struct packed {
        logic       dll_off;
        logic       half_drive;
        logic [1:0] odt;
        logic [2:0] add_lat;
        logic [2:0] ocd;
        logic       dqs_off;
        logic       rdqs_on;
        logic       out_off;
    } emr_fields_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] STB_NOP  = 4'b0111;
    localparam logic [3:0] STB_LOAD = 4'b0000;
    localparam logic [1:0] BA_EXT1  = 2'b01;

    localparam int FIELD_BITS = 13;

endpackage

// File: rtl/emr_addr_pack.sv
module emr_addr_pack
    import ddr2_emr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  emr_fields_t        fields,
    output logic [ADDR_W-1:0]  word
);
    always_comb begin
        word        = '0;
        word[0]     = fields.dll_off;
        word[1]     = fields.half_drive;
        word[2]     = fields.odt[0];
        word[5:3]   = fields.add_lat;
        word[6]     = fields.odt[1];
        word[9:7]   = fields.ocd;
        word[10]    = fields.dqs_off;
        word[11]    = fields.rdqs_on;
        word[12]    = fields.out_off;
    end
endmodule

// File: rtl/emr_cmd_fsm.sv
module emr_cmd_fsm
    import ddr2_emr_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int TMRD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] word_in,
    input  logic              banks_idle,
    input  logic              cke_high,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              cmd_fire,
    output logic              fire_dll_off
);
    localparam int CW = $clog2(TMRD + 1);
    localparam logic [CW-1:0] MRD_LOAD = CW'(TMRD - 1);

    emr_state_e        state, state_nx;
    logic [CW-1:0]     mrd_cnt;
    logic [ADDR_W-1:0] word_q;
    logic              gate_open;

    assign gate_open = banks_idle && cke_high;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (req_valid) state_nx = ST_WAIT_GATE;
            ST_WAIT_GATE: if (gate_open) state_nx = ST_ISSUE;
            ST_ISSUE:     state_nx = (TMRD > 1) ? ST_MRD_WAIT : ST_IDLE;
            ST_MRD_WAIT:  if (mrd_cnt <= CW'(1)) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mrd_cnt <= '0;
            word_q  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) word_q <= word_in;
            if (state == ST_ISSUE)
                mrd_cnt <= MRD_LOAD;
            else if (state == ST_MRD_WAIT && mrd_cnt != '0)
                mrd_cnt <= mrd_cnt - CW'(1);
        end
    end

    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = STB_NOP;
        ba           = '0;
        addr         = '0;
        req_ready    = 1'b0;
        busy         = 1'b1;
        cmd_fire     = 1'b0;
        fire_dll_off = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
            end
            ST_WAIT_GATE: ;
            ST_ISSUE: begin
                {cs_n, ras_n, cas_n, we_n} = STB_LOAD;
                ba           = BA_EXT1;
                addr         = word_q;
                cmd_fire     = 1'b1;
                fire_dll_off = word_q[0];
            end
            ST_MRD_WAIT: ;
            default: ;
        endcase
    end

    // cycles since the last command, saturating at TMRD
    logic [CW-1:0] since_cmd;
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_cmd <= CW'(TMRD);
        else if (cmd_fire)           since_cmd <= CW'(1);
        else if (since_cmd < CW'(TMRD)) since_cmd <= since_cmd + CW'(1);
    end

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n == 1'b0) |=> (ras_n == 1'b1 && cs_n == 1'b0)); // R2
    AST_GATE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE) |-> $past(banks_idle && cke_high)); // R4
    AST_MRD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE) |-> (since_cmd >= CW'(TMRD))); // R5
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready)); // R6
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE) |-> $stable(word_q)); // R6
endmodule

// File: rtl/dll_read_lockout.sv
module dll_read_lockout #(
    parameter int DLL_LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dll_reset_evt,
    input  logic self_refresh,
    input  logic cmd_fire,
    input  logic cmd_dll_off,
    output logic read_allowed
);
    localparam int LW = $clog2(DLL_LOCK_CYC + 1);
    localparam logic [LW-1:0] LOCK_LOAD = LW'(DLL_LOCK_CYC);

    logic [LW-1:0] lock_cnt;
    logic          loaded;
    logic          dll_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_cnt <= '0;
            loaded   <= 1'b0;
            dll_on   <= 1'b0;
        end else begin
            if (dll_reset_evt || self_refresh)
                lock_cnt <= LOCK_LOAD;
            else if (lock_cnt != '0)
                lock_cnt <= lock_cnt - LW'(1);
            if (cmd_fire) begin
                loaded <= 1'b1;
                dll_on <= !cmd_dll_off;
            end
        end
    end

    assign read_allowed = loaded && dll_on && (lock_cnt == '0);

    AST_RESET_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset_evt |=> !read_allowed); // R7
    AST_SREF_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        self_refresh |=> !read_allowed); // R8
    AST_DLL_OFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_dll_off) |=> !read_allowed); // R9
    AST_RISE_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_allowed) |-> !$past(dll_reset_evt || self_refresh)); // R7
endmodule

// File: rtl/ddr2_ext_mode_prog.sv
module ddr2_ext_mode_prog
    import ddr2_emr_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int TMRD         = 2,
    parameter int DLL_LOCK_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              cfg_dll_off,
    input  logic              cfg_half_drive,
    input  logic [1:0]        cfg_odt,
    input  logic [2:0]        cfg_add_lat,
    input  logic [2:0]        cfg_ocd,
    input  logic              cfg_dqs_off,
    input  logic              cfg_rdqs_on,
    input  logic              cfg_out_off,
    input  logic              banks_idle,
    input  logic              cke_high,
    input  logic              dll_reset_evt,
    input  logic              self_refresh,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              read_allowed
);
    emr_fields_t       fields;
    logic [ADDR_W-1:0] packed_word;
    logic              cmd_fire;
    logic              fire_dll_off;

    assign fields = '{dll_off: cfg_dll_off, half_drive: cfg_half_drive,
                      odt: cfg_odt, add_lat: cfg_add_lat, ocd: cfg_ocd,
                      dqs_off: cfg_dqs_off, rdqs_on: cfg_rdqs_on,
                      out_off: cfg_out_off};

    emr_addr_pack #(.ADDR_W(ADDR_W)) u_pack (
        .fields (fields),
        .word   (packed_word)
    );

    emr_cmd_fsm #(.ADDR_W(ADDR_W), .TMRD(TMRD)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .word_in      (packed_word),
        .banks_idle   (banks_idle),
        .cke_high     (cke_high),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .ba           (ba),
        .addr         (addr),
        .busy         (busy),
        .cmd_fire     (cmd_fire),
        .fire_dll_off (fire_dll_off)
    );

    dll_read_lockout #(.DLL_LOCK_CYC(DLL_LOCK_CYC)) u_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .dll_reset_evt (dll_reset_evt),
        .self_refresh  (self_refresh),
        .cmd_fire      (cmd_fire),
        .cmd_dll_off   (fire_dll_off),
        .read_allowed  (read_allowed)
    );
endmodule

// File: tb/test_ddr2_ext_mode_prog.sv
`timescale 1ns/1ps
module test_ddr2_ext_mode_prog;
    localparam int AW   = 14;
    localparam int MRD  = 2;
    localparam int LOCK = 200;
    localparam int NV   = 6;

    // {fields[12:0], expected address[13:0]}
    // fields: [12]dll_off [11]half [10:9]odt [8:6]al [5:3]ocd [2]dqs [1]rdqs [0]qoff
    localparam logic [26:0] VEC [NV] = '{
        {13'h0000, 14'h0000},
        {13'h1000, 14'h0001},
        {13'h0A00, 14'h0006},
        {13'h0540, 14'h0068},
        {13'h003C, 14'h0780},
        {13'h0083, 14'h1810}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [12:0] fld = '0;
    logic banks_idle = 1'b1, cke_high = 1'b1;
    logic dll_reset_evt = 1'b0, self_refresh = 1'b0;
    logic req_ready, cs_n, ras_n, cas_n, we_n, busy, read_allowed;
    logic [1:0] ba;
    logic [AW-1:0] addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ddr2_ext_mode_prog #(.ADDR_W(AW), .TMRD(MRD), .DLL_LOCK_CYC(LOCK)) i_ddr2_ext_mode_prog (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .cfg_dll_off(fld[12]), .cfg_half_drive(fld[11]), .cfg_odt(fld[10:9]),
        .cfg_add_lat(fld[8:6]), .cfg_ocd(fld[5:3]), .cfg_dqs_off(fld[2]),
        .cfg_rdqs_on(fld[1]), .cfg_out_off(fld[0]),
        .banks_idle(banks_idle), .cke_high(cke_high),
        .dll_reset_evt(dll_reset_evt), .self_refresh(self_refresh),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
        .addr(addr), .busy(busy), .read_allowed(read_allowed)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe bundle {cs_n,ras_n,cas_n,we_n,ba,addr}
    function automatic logic [31:0] pins();
        return 32'({cs_n, ras_n, cas_n, we_n, ba, addr});
    endfunction

    function automatic logic [31:0] nop_pins();
        return 32'({4'b0111, 2'b00, {AW{1'b0}}});
    endfunction

    function automatic logic [31:0] cmd_pins(input logic [AW-1:0] a);
        return 32'({4'b0000, 2'b01, a});
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 pins", pins(), nop_pins());
        check("R1 busy", 32'(busy), 0);
        check("R1 ready", 32'(req_ready), 1);
        check("R9 read_allowed before first write", 32'(read_allowed), 0);

        // table walk: R2, R3, R5, R6, R9
        for (int i = 0; i < NV; i++) begin
            fld       = VEC[i][26:14];
            req_valid = 1'b1;
            step(1);                      // accepted at the edge just passed
            req_valid = 1'b0;
            fld       = ~VEC[i][26:14];   // R6: must not leak into the command
            check("R6 busy after accept", 32'(busy), 1);
            check("R6 ready low after accept", 32'(req_ready), 0);
            check("R2 no command while gating", pins(), nop_pins());
            step(1);
            check("R3 command pins and address", pins(), cmd_pins(VEC[i][13:0]));
            step(1);
            check("R2 back to NOP", pins(), nop_pins());
            check("R5 busy during cycle time", 32'(busy), 1);
            check("R5 ready low during cycle time", 32'(req_ready), 0);
            step(1);
            check("R5 idle after cycle time", 32'(busy), 0);
            check("R6 ready when idle", 32'(req_ready), 1);
            check("R9 read_allowed follows DLL bit", 32'(read_allowed), 32'(!VEC[i][26]));
        end

        // R4: gate closed by banks, then by clock enable
        banks_idle = 1'b0;
        fld        = VEC[3][26:14];
        req_valid  = 1'b1;
        step(1);
        req_valid  = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R4 held while banks open", pins(), nop_pins());
            check("R4 pending busy", 32'(busy), 1);
            step(1);
        end
        banks_idle = 1'b1;
        cke_high   = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step(1);
            check("R4 held while CKE low", pins(), nop_pins());
        end
        cke_high = 1'b1;
        step(1);
        check("R4 issued once gate open", pins(), cmd_pins(VEC[3][13:0]));
        step(2);
        check("R5 idle after gated command", 32'(busy), 0);

        // R7: DLL reset lockout boundary
        check("R7 allowed before pulse", 32'(read_allowed), 1);
        dll_reset_evt = 1'b1;
        step(1);
        dll_reset_evt = 1'b0;
        check("R7 blocked right after pulse", 32'(read_allowed), 0);
        step(LOCK - 1);
        check("R7 still blocked at last cycle", 32'(read_allowed), 0);
        step(1);
        check("R7 allowed after lockout", 32'(read_allowed), 1);

        // R8: self-refresh holds and restarts the lockout
        self_refresh = 1'b1;
        step(1);
        for (int k = 0; k < 5; k++) begin
            check("R8 blocked in self-refresh", 32'(read_allowed), 0);
            step(1);
        end
        self_refresh = 1'b0;
        step(LOCK - 1);
        check("R8 blocked until count ends", 32'(read_allowed), 0);
        step(1);
        check("R8 allowed after exit lockout", 32'(read_allowed), 1);

        // R9: writing DLL off blocks reads with no lockout pending
        fld       = VEC[1][26:14];
        req_valid = 1'b1;
        step(1);
        req_valid = 1'b0;
        step(3);
        check("R9 blocked with DLL off", 32'(read_allowed), 0);

        // R1: reset in mid-flight returns to the reset state
        fld       = VEC[2][26:14];
        req_valid = 1'b1;
        step(1);
        req_valid = 1'b0;
        rst_n     = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(1);
        check("R1 pins after reset", pins(), nop_pins());
        check("R1 ready after reset", 32'(req_ready), 1);
        check("R1 read_allowed after reset", 32'(read_allowed), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule